// File: doc/BRIEF.md
# Capture and PWM timer channel

One channel of a memory-mapped timer built around a single 16-bit up-counter. The counter counts one step per clock while it is running. It is zeroed by a software trigger, by a synchronous restart pulse, or by a match with the period register when that restart is enabled.

A mode bit chooses between two uses of the same counter. In capture mode, chosen edges of an asynchronous input pin load the count into two capture registers. In waveform mode, three compare registers shape two PWM outputs. Four sticky status flags record overflow, the two capture or compare events, and the period match. Reading the status register clears the flags. An interrupt output is raised whenever an enabled flag is set.

Software sees a simple synchronous register bus. Reads have a one-cycle latency.

Top module: `tmr_channel`

## Requirements
- R1: The command register at 0x00 controls the clock. Writing bit0 starts the counter and writing bit1 stops it; bit1 wins when both are written. While running, the counter at 0x10 rises by one per clock. While stopped, it holds its value.
- R2: Writing bit2 of the command register, or a one-cycle high on `sync_i`, zeroes the counter on the next clock, whether or not it is running.
- R3: When a running counter steps from 0xFFFF to 0, status bit0 (overflow) is set.
- R4: While the counter is running and equals the period register (0x1C), status bit3 is set, in both modes. If mode bit5 is 1, the counter is zeroed on the next clock instead of incrementing.
- R5: Capture mode is selected by mode register (0x04) bit0 = 0. `cap_i` passes through two synchroniser flops before edge detection. Mode bits[2:1] choose the edge that loads capture register A (0x14) and bits[4:3] choose the edge that loads B (0x18), coded 0 none, 1 rising, 2 falling, 3 both. A pin change made before clock edge k loads the count present just before edge k+2. A load of A sets status bit1 and a load of B sets status bit2. A capture load wins over a bus write in the same cycle.
- R6: In waveform mode (mode bit0 = 1), a running counter equal to register A sets status bit1, and a running counter equal to register B sets status bit2.
- R7: In waveform mode, an A match drives `out_a` high and a B match drives `out_b` high on the next clock. A period match drives both low, and it wins over the A and B matches. A software trigger or sync pulse returns the outputs to their initial levels, given by mode bit6 (`out_a`) and bit7 (`out_b`). In capture mode, both outputs stay at their initial levels.
- R8: A read of the status register (0x20) returns the flags and clears them. A flag set in the same cycle as the read remains set.
- R9: The interrupt enable register (0x24) holds mask bits[3:0]. `irq` is high exactly when some status flag and its enable bit are both set, in the same cycle as that flag.
- R10: `bus_rdata` carries a register value in the cycle after its read request. It is 0 when there is no read and for unmapped addresses. After reset, all registers, outputs and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| cap_i | input | 1 | Asynchronous capture pin |
| sync_i | input | 1 | Synchronous counter restart pulse |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| irq | output | 1 | Interrupt request |

## Verification
The channel runs from several starting points, and every port is compared against a behavioural model on every cycle. A free count with stop and start, and with both command bits written at once, separates holding from stepping and shows which command wins. Period restarts with A and B compares, including A equal to the period, show whether the clear is taken over the set and whether the two output levels are independent. Capture pulses under the rising, falling, both and none settings, including one-cycle pulses, show the synchroniser latency and the edge decode. A full 65536-step run isolates the overflow flag, and status reads issued back to back while matches keep firing show that a new event survives a clearing read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic      out_b_init;
    logic      out_a_init;
    logic      rc_restart;
    edge_sel_e edge_b;
    edge_sel_e edge_a;
    logic      wave;
  } mode_t;

  localparam logic [7:0] A_CMD  = 8'h00;
  localparam logic [7:0] A_MODE = 8'h04;
  localparam logic [7:0] A_CNT  = 8'h10;
  localparam logic [7:0] A_RA   = 8'h14;
  localparam logic [7:0] A_RB   = 8'h18;
  localparam logic [7:0] A_RC   = 8'h1C;
  localparam logic [7:0] A_STAT = 8'h20;
  localparam logic [7:0] A_IEN  = 8'h24;

  localparam int ST_OVF = 0;
  localparam int ST_A   = 1;
  localparam int ST_B   = 2;
  localparam int ST_C   = 3;
  localparam int ST_W   = 4;

  localparam int CMD_EN  = 0;
  localparam int CMD_DIS = 1;
  localparam int CMD_TRG = 2;

  localparam int MODE_W = $bits(mode_t);

  function automatic logic edge_hit(edge_sel_e s, logic r, logic f);
    case (s)
      EDGE_RISE: return r;
      EDGE_FALL: return f;
      EDGE_BOTH: return r | f;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

  // R5: a detected edge lasts exactly one cycle
  p_edge_single_r5: assert property (@(posedge clk) disable iff (rst)
    (rise || fall) |=> !(rise || fall) || ($past(rise) != rise));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_set,
  input  logic           en_clr,
  input  logic           restart,
  input  logic           rc_restart_en,
  input  logic [2:0][W-1:0] cmp,
  output logic [W-1:0]   cnt,
  output logic [2:0]     hit,
  output logic           wrap
);
  logic         run_q;
  logic [W-1:0] cnt_q;
  logic         zero;

  for (genvar i = 0; i < 3; i++) begin : g_cmp
    assign hit[i] = run_q && (cnt_q == cmp[i]);
  end

  assign zero = restart || (hit[2] && rc_restart_en);
  assign wrap = run_q && (&cnt_q) && !zero;
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (en_clr)      run_q <= 1'b0;
      else if (en_set) run_q <= 1'b1;
      if (zero)        cnt_q <= '0;
      else if (run_q)  cnt_q <= cnt_q + 1'b1;
    end
  end

  p_restart_zero_r2: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt_q == '0);

  p_hold_stopped_r1: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !restart) |=> $stable(cnt_q));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt_q == '0);

  p_rc_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (hit[2] && rc_restart_en) |=> cnt_q == '0);
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wave,
  input  logic         restart,
  input  logic [N-1:0] set,
  input  logic         clr,
  input  logic [N-1:0] init,
  output logic [N-1:0] out
);
  for (genvar i = 0; i < N; i++) begin : g_out
    logic q;
    always_ff @(posedge clk) begin
      if (rst)                  q <= 1'b0;
      else if (!wave || restart) q <= init[i];
      else if (clr)             q <= 1'b0;
      else if (set[i])          q <= 1'b1;
    end
    assign out[i] = q;

    // R7: a period match lowers the output unless a restart intervenes
    p_rc_clear_r7: assert property (@(posedge clk) disable iff (rst)
      (wave && !restart && clr) |=> !q);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap_i,
  input  logic              sync_i,
  output logic              out_a,
  output logic              out_b,
  output logic              irq
);
  import tmr_pkg::*;

  localparam logic [ADDR_W-1:0] AD_CMD  = ADDR_W'(A_CMD);
  localparam logic [ADDR_W-1:0] AD_MODE = ADDR_W'(A_MODE);
  localparam logic [ADDR_W-1:0] AD_CNT  = ADDR_W'(A_CNT);
  localparam logic [ADDR_W-1:0] AD_RA   = ADDR_W'(A_RA);
  localparam logic [ADDR_W-1:0] AD_RB   = ADDR_W'(A_RB);
  localparam logic [ADDR_W-1:0] AD_RC   = ADDR_W'(A_RC);
  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);

  logic wr, rd, wr_cmd, rd_stat, sw_trg, restart;
  mode_t mode_q;
  logic [CNT_W-1:0] ra_q, rb_q, rc_q, cnt;
  logic [ST_W-1:0]  stat_q, stat_d, ien_q, ien_d, set_v;
  logic [DATA_W-1:0] rdata_q, rd_val;
  logic irq_q;
  logic [2:0] hit;
  logic wrap, rise, fall, cap_a, cap_b;
  logic [1:0] wout;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr      = bus_sel & bus_wr;
  assign rd      = bus_sel & ~bus_wr;
  assign wr_cmd  = wr && (bus_addr == AD_CMD);
  assign rd_stat = rd && (bus_addr == AD_STAT);
  assign sw_trg  = wr_cmd && bus_wdata[CMD_TRG];
  assign restart = sw_trg | sync_i;

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk           (clk),
    .rst           (rst),
    .en_set        (wr_cmd && bus_wdata[CMD_EN]),
    .en_clr        (wr_cmd && bus_wdata[CMD_DIS]),
    .restart       (restart),
    .rc_restart_en (mode_q.rc_restart),
    .cmp           ({rc_q, rb_q, ra_q}),
    .cnt           (cnt),
    .hit           (hit),
    .wrap          (wrap)
  );

  tmr_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (cap_i),
    .rise (rise),
    .fall (fall)
  );

  assign cap_a = !mode_q.wave && edge_hit(mode_q.edge_a, rise, fall);
  assign cap_b = !mode_q.wave && edge_hit(mode_q.edge_b, rise, fall);

  always_comb begin
    set_v         = '0;
    set_v[ST_OVF] = wrap;
    set_v[ST_A]   = mode_q.wave ? hit[0] : cap_a;
    set_v[ST_B]   = mode_q.wave ? hit[1] : cap_b;
    set_v[ST_C]   = hit[2];
  end

  assign stat_d = set_v | (rd_stat ? '0 : stat_q);
  assign ien_d  = (wr && bus_addr == AD_IEN) ? bus_wdata[ST_W-1:0] : ien_q;

  always_comb begin
    rd_val = '0;
    if (rd) begin
      case (bus_addr)
        AD_MODE: rd_val = DATA_W'(mode_q);
        AD_CNT:  rd_val = DATA_W'(cnt);
        AD_RA:   rd_val = DATA_W'(ra_q);
        AD_RB:   rd_val = DATA_W'(rb_q);
        AD_RC:   rd_val = DATA_W'(rc_q);
        AD_STAT: rd_val = DATA_W'(stat_q);
        AD_IEN:  rd_val = DATA_W'(ien_q);
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      ra_q    <= '0;
      rb_q    <= '0;
      rc_q    <= '0;
      stat_q  <= '0;
      ien_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr && bus_addr == AD_MODE) mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
      if (cap_a)                          ra_q <= cnt;
      else if (wr && bus_addr == AD_RA)   ra_q <= bus_wdata[CNT_W-1:0];
      if (cap_b)                          rb_q <= cnt;
      else if (wr && bus_addr == AD_RB)   rb_q <= bus_wdata[CNT_W-1:0];
      if (wr && bus_addr == AD_RC)        rc_q <= bus_wdata[CNT_W-1:0];
      stat_q  <= stat_d;
      ien_q   <= ien_d;
      rdata_q <= rd_val;
      irq_q   <= |(stat_d & ien_d);
    end
  end

  tmr_wave #(.N(2)) u_wave (
    .clk     (clk),
    .rst     (rst),
    .wave    (mode_q.wave),
    .restart (restart),
    .set     ({hit[1], hit[0]}),
    .clr     (hit[2]),
    .init    ({mode_q.out_b_init, mode_q.out_a_init}),
    .out     (wout)
  );

  assign out_a     = wout[0];
  assign out_b     = wout[1];
  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  p_cap_load_r5: assert property (@(posedge clk) disable iff (rst)
    cap_a |=> ra_q == $past(cnt));

  p_stat_read_r8: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> bus_rdata == DATA_W'($past(stat_q)));

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> |stat_q);

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
    !rd |=> bus_rdata == '0);
endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        sel = 1'b0, wr = 1'b0, cap = 1'b0, sync = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        oa, ob, irq;

  tmr_channel dut (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .cap_i(cap), .sync_i(sync),
    .out_a(oa), .out_b(ob), .irq(irq)
  );

  int checks = 0, fails = 0;
  string cur_req = "R10";
  bit done = 0;

  int m_cnt = 0, m_en = 0, m_wave = 0, m_ea = 0, m_eb = 0, m_rcr = 0;
  int m_ia = 0, m_ib = 0, m_ra = 0, m_rb = 0, m_rc = 0, m_st = 0, m_ie = 0;
  int m_oa = 0, m_ob = 0, m_rd = 0, m_irq = 0;
  int hist[$] = '{0, 0, 0};

  function automatic int sel_hit(int s, int r, int f);
    if (s == 1) return r;
    if (s == 2) return f;
    if (s == 3) return (r || f) ? 1 : 0;
    return 0;
  endfunction

  // behavioural reference, advanced at each rising edge from pre-edge values
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_en = 0; m_wave = 0; m_ea = 0; m_eb = 0; m_rcr = 0;
      m_ia = 0; m_ib = 0; m_ra = 0; m_rb = 0; m_rc = 0; m_st = 0; m_ie = 0;
      m_oa = 0; m_ob = 0; m_rd = 0; m_irq = 0;
      hist = '{0, 0, 0};
    end else begin
      int w, r, ha, hb, hc, trig, zero, ovf, rise, fall, ca, cb, setv, rv, d;
      int n_oa, n_ob;
      d = int'(wdata);
      w = (sel && wr) ? 1 : 0;
      r = (sel && !wr) ? 1 : 0;
      ha = (m_en && m_cnt == m_ra) ? 1 : 0;
      hb = (m_en && m_cnt == m_rb) ? 1 : 0;
      hc = (m_en && m_cnt == m_rc) ? 1 : 0;
      trig = (w && addr == 8'h00 && wdata[2]) ? 1 : 0;
      zero = (trig || sync || (hc && m_rcr)) ? 1 : 0;
      ovf = (m_en && m_cnt == 65535 && !zero) ? 1 : 0;
      rise = (hist[1] == 1 && hist[2] == 0) ? 1 : 0;
      fall = (hist[1] == 0 && hist[2] == 1) ? 1 : 0;
      ca = (!m_wave && sel_hit(m_ea, rise, fall)) ? 1 : 0;
      cb = (!m_wave && sel_hit(m_eb, rise, fall)) ? 1 : 0;
      setv = ovf | ((m_wave ? ha : ca) << 1) | ((m_wave ? hb : cb) << 2) | (hc << 3);
      rv = 0;
      if (r) begin
        case (addr)
          8'h04: rv = m_wave | (m_ea << 1) | (m_eb << 3) | (m_rcr << 5) | (m_ia << 6) | (m_ib << 7);
          8'h10: rv = m_cnt;
          8'h14: rv = m_ra;
          8'h18: rv = m_rb;
          8'h1C: rv = m_rc;
          8'h20: rv = m_st;
          8'h24: rv = m_ie;
          default: rv = 0;
        endcase
      end
      n_oa = m_oa; n_ob = m_ob;
      if (!m_wave || trig || sync) begin
        n_oa = m_ia; n_ob = m_ib;
      end else begin
        if (hc) n_oa = 0; else if (ha) n_oa = 1;
        if (hc) n_ob = 0; else if (hb) n_ob = 1;
      end
      m_oa = n_oa; m_ob = n_ob;
      if (w && addr == 8'h00) begin
        if (wdata[1]) m_en = 0; else if (wdata[0]) m_en = 1;
      end
      if (ca) m_ra = m_cnt; else if (w && addr == 8'h14) m_ra = d & 16'hFFFF;
      if (cb) m_rb = m_cnt; else if (w && addr == 8'h18) m_rb = d & 16'hFFFF;
      if (w && addr == 8'h1C) m_rc = d & 16'hFFFF;
      m_cnt = zero ? 0 : (m_en_prev(m_cnt, ha, hb) );
      if (w && addr == 8'h04) begin
        m_wave = d & 1; m_ea = (d >> 1) & 3; m_eb = (d >> 3) & 3;
        m_rcr = (d >> 5) & 1; m_ia = (d >> 6) & 1; m_ib = (d >> 7) & 1;
      end
      m_st = setv | ((r && addr == 8'h20) ? 0 : m_st);
      if (w && addr == 8'h24) m_ie = d & 15;
      m_irq = ((m_st & m_ie) != 0) ? 1 : 0;
      m_rd = rv;
      hist.push_front(cap ? 1 : 0);
      void'(hist.pop_back());
    end
  end

  // counter step helper: uses the run state latched before this edge
  int run_before = 0;
  always @(negedge clk) run_before = m_en;
  function automatic int m_en_prev(int c, int a, int b);
    if (run_before != 0) return (c + 1) & 16'hFFFF;
    return c;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "rdata", int'(rdata), m_rd);
      chk(cur_req, "out_a", int'(oa), m_oa);
      chk(cur_req, "out_b", int'(ob), m_ob);
      chk(cur_req, "irq",   int'(irq), m_irq);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0; addr = '0; wdata = '0;
  endtask

  task automatic rreg(logic [7:0] a);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    @(negedge clk); sel = 0; addr = '0;
  endtask

  task automatic pulse_cap(int hi, int lo);
    @(negedge clk); cap = 1; idle(hi);
    cap = 0; idle(lo);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state and read behaviour
    cur_req = "R10";
    @(negedge clk);
    chk("R10", "reset rdata", int'(rdata), 0);
    chk("R10", "reset irq", int'(irq), 0);
    rreg(8'h04); rreg(8'h30); rreg(8'h10);

    cur_req = "R1";
    wreg(8'h1C, 32'd1000);
    wreg(8'h00, 32'd1); idle(15); rreg(8'h10);
    wreg(8'h00, 32'd2); idle(5); rreg(8'h10); rreg(8'h10);
    wreg(8'h00, 32'd1); idle(4); wreg(8'h00, 32'd3); idle(3); rreg(8'h10);

    cur_req = "R2";
    wreg(8'h00, 32'd4); rreg(8'h10);
    wreg(8'h00, 32'd1); idle(10);
    @(negedge clk); sync = 1; @(negedge clk); sync = 0;
    idle(3); rreg(8'h10);

    cur_req = "R4";
    wreg(8'h24, 32'hF); wreg(8'h1C, 32'd9); wreg(8'h04, 32'h20);
    wreg(8'h00, 32'd4); idle(25); rreg(8'h20); rreg(8'h20); rreg(8'h10);

    cur_req = "R9";
    wreg(8'h24, 32'h8); idle(12); wreg(8'h24, 32'h0); idle(12);
    rreg(8'h20); wreg(8'h24, 32'h1); idle(12); rreg(8'h20);

    cur_req = "R5";
    wreg(8'h1C, 32'd300); wreg(8'h04, 32'h12);
    wreg(8'h00, 32'd4); idle(5);
    pulse_cap(7, 6); rreg(8'h14); rreg(8'h18); rreg(8'h20);
    wreg(8'h04, 32'h06); pulse_cap(1, 5); pulse_cap(3, 4);
    rreg(8'h14); rreg(8'h18); rreg(8'h20);
    wreg(8'h04, 32'h18); pulse_cap(2, 5); rreg(8'h14); rreg(8'h18);
    wreg(8'h04, 32'h00); pulse_cap(4, 6); rreg(8'h14); rreg(8'h18); rreg(8'h20);
    @(negedge clk); cap = 1; wreg(8'h04, 32'h02); idle(1); wreg(8'h14, 32'h55); idle(4);
    cap = 0; idle(4); rreg(8'h14);

    cur_req = "R6";
    wreg(8'h14, 32'd3); wreg(8'h18, 32'd6); wreg(8'h1C, 32'd10);
    wreg(8'h04, 32'hA1); wreg(8'h00, 32'd4); idle(30); rreg(8'h20);

    cur_req = "R7";
    idle(15); wreg(8'h00, 32'd4); idle(5);
    @(negedge clk); sync = 1; @(negedge clk); sync = 0; idle(8);
    wreg(8'h14, 32'd10); idle(25);
    wreg(8'h18, 32'd0); idle(15);
    wreg(8'h04, 32'h61); idle(20);
    wreg(8'h04, 32'h40); idle(5);

    cur_req = "R8";
    wreg(8'h24, 32'hF); wreg(8'h04, 32'h21);
    wreg(8'h14, 32'd2); wreg(8'h18, 32'd3); wreg(8'h1C, 32'd4);
    repeat (12) rreg(8'h20);
    @(negedge clk); sel = 1; wr = 0; addr = 8'h20;
    idle(10); sel = 0; addr = '0; idle(2);

    cur_req = "R3";
    wreg(8'h04, 32'h00); wreg(8'h1C, 32'd40000); wreg(8'h24, 32'h1);
    rreg(8'h20); wreg(8'h00, 32'd5);
    idle(65545); rreg(8'h20); rreg(8'h20); rreg(8'h10);

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL %s watchdog actual=expired expected=finished", cur_req);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule